// File: doc/BRIEF.md
# GPIO Bank with Interrupt Detection

This block is one bank of 32 general-purpose pins behind a small register bus. Each request is a single-cycle strobe carrying a write flag, a byte address and 32-bit write data. Software sets an output value and a direction per pin, and reads back the real pin levels. Pad inputs are first passed through a synchronizer.

The same synchronized inputs feed a per-pin interrupt detector. A type bit chooses between level sensing and edge sensing, and a polarity bit chooses which level or which edge counts as active. Edge events are held in a latch until software acknowledges them by writing ones to the acknowledge address. Enable and mask registers produce a raw view and a masked view of the pending pins. The masked pins are ORed into one registered interrupt line, and software is expected to service pending bits starting from the lowest one.

Top module: `gpio_bank`

## Requirements
- R1: A synchronous reset clears every register to 0. After reset every pin is an input, no interrupt is enabled, and `irq`, `pad_oe`, `pad_out` and `bus_rdata` are 0.
- R2: The output-value register (0x00) drives `pad_out`, and the direction register (0x04) drives `pad_oe` (1 = output, 0 = input). Both change on the clock edge that takes the write, and both read back what was written.
- R3: Reading the pin-level register (0x50) returns the output-value bit for output pins. For input pins it returns `pad_in` delayed by the two-stage synchronizer.
- R4: A pin with type bit 0 (register 0x38) is level sensed. Polarity 1 (register 0x3C) means active high and polarity 0 means active low. Its raw bit follows the synchronized level and clears once the input goes inactive.
- R5: A pin with type bit 1 is edge sensed. Polarity 1 detects a rising edge and polarity 0 detects a falling edge. A detected edge on an enabled pin is held until it is acknowledged. The opposite edge has no effect.
- R6: Writing 1 to a bit of the acknowledge address (0x4C) clears that pin's held edge, and bits written as 0 leave their pins unchanged. If a new edge arrives in the same cycle as the acknowledge, the edge wins and the bit stays set.
- R7: Raw status (0x44) shows the detected condition of each enabled pin (enable register 0x30), whatever the mask. Masked status (0x40) is raw AND NOT mask (mask register 0x34, 1 = masked).
- R8: `irq` is the OR of all masked status bits and is registered, so it follows status one cycle later.
- R9: The filter register (0x48) and the sync-mode register (0x60) are read/write but do not affect detection. Writes to the read-only addresses 0x40, 0x44 and 0x50 are ignored.
- R10: A read returns its data on `bus_rdata` one cycle after the request and holds it until the next read. Unmapped addresses and 0x4C read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Request strobe, one cycle per access |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_out | output | 32 | Output value per pin |
| pad_oe | output | 32 | Output enable per pin |
| irq | output | 1 | Combined interrupt |

## Verification
The key collision is an acknowledge write landing in the same cycle that a new edge is detected on the same pin. The bench changes the pad and then times the acknowledge write to be sampled on the third clock edge after the change, the edge on which detection fires. Raw status must still show the pin afterwards. A cycle-accurate behavioural model runs alongside, and its `irq`, pad outputs and read data are compared on every clock.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam logic [7:0] OFF_DOUT  = 8'h00;
  localparam logic [7:0] OFF_DIR   = 8'h04;
  localparam logic [7:0] OFF_IEN   = 8'h30;
  localparam logic [7:0] OFF_IMSK  = 8'h34;
  localparam logic [7:0] OFF_ITYP  = 8'h38;
  localparam logic [7:0] OFF_IPOL  = 8'h3C;
  localparam logic [7:0] OFF_ISTAT = 8'h40;
  localparam logic [7:0] OFF_IRAW  = 8'h44;
  localparam logic [7:0] OFF_FILT  = 8'h48;
  localparam logic [7:0] OFF_ACK   = 8'h4C;
  localparam logic [7:0] OFF_PINS  = 8'h50;
  localparam logic [7:0] OFF_SMODE = 8'h60;
endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] st [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) st[g] <= '0;
      else if (g == 0) st[g] <= d;
      else st[g] <= st[(g == 0) ? 0 : g-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/gpio_bank_detect.sv
module gpio_bank_detect #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] lvl_in,
  input  logic [W-1:0] ien,
  input  logic [W-1:0] imsk,
  input  logic [W-1:0] ityp,
  input  logic [W-1:0] ipol,
  input  logic [W-1:0] ack,
  output logic [W-1:0] raw,
  output logic [W-1:0] status
);
  logic [W-1:0] prev;
  logic [W-1:0] held;

  always_ff @(posedge clk) begin
    if (rst) prev <= '0;
    else     prev <= lvl_in;
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic rise, fall, hit, active, lat;
    assign rise   = lvl_in[i] & ~prev[i];
    assign fall   = ~lvl_in[i] & prev[i];
    assign hit    = ipol[i] ? rise : fall;
    assign active = ipol[i] ? lvl_in[i] : ~lvl_in[i];

    always_ff @(posedge clk) begin
      if (rst) lat <= 1'b0;
      else     lat <= ien[i] & ityp[i] & (hit | (lat & ~ack[i]));
    end

    assign held[i] = lat;
    assign raw[i]  = ien[i] & (ityp[i] ? held[i] : active);
  end

  assign status = raw & ~imsk;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int W         = 32,
  parameter int ADDR_W    = 8,
  parameter int SYNC_STGS = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pad_in,
  output logic [W-1:0]      pad_out,
  output logic [W-1:0]      pad_oe,
  output logic              irq
);
  logic [W-1:0] reg_dout, reg_dir, reg_ien, reg_imsk, reg_ityp, reg_ipol;
  logic [W-1:0] reg_filt, reg_smode;
  logic [W-1:0] pin_sync, pin_level, irq_raw, irq_status, ack_vec, rd_mux;
  logic         wr_go, rd_go;

  assign wr_go = bus_valid & bus_write;
  assign rd_go = bus_valid & ~bus_write;

  gpio_bank_sync #(.W(W), .STAGES(SYNC_STGS)) u_sync (
    .clk(clk), .rst(rst), .d(pad_in), .q(pin_sync)
  );

  assign ack_vec = (wr_go && bus_addr == ADDR_W'(OFF_ACK)) ? bus_wdata : '0;

  gpio_bank_detect #(.W(W)) u_det (
    .clk(clk), .rst(rst), .lvl_in(pin_sync),
    .ien(reg_ien), .imsk(reg_imsk), .ityp(reg_ityp), .ipol(reg_ipol),
    .ack(ack_vec), .raw(irq_raw), .status(irq_status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_dout <= '0; reg_dir  <= '0; reg_ien   <= '0; reg_imsk <= '0;
      reg_ityp <= '0; reg_ipol <= '0; reg_filt  <= '0; reg_smode <= '0;
    end else if (wr_go) begin
      case (bus_addr)
        ADDR_W'(OFF_DOUT):  reg_dout  <= bus_wdata;
        ADDR_W'(OFF_DIR):   reg_dir   <= bus_wdata;
        ADDR_W'(OFF_IEN):   reg_ien   <= bus_wdata;
        ADDR_W'(OFF_IMSK):  reg_imsk  <= bus_wdata;
        ADDR_W'(OFF_ITYP):  reg_ityp  <= bus_wdata;
        ADDR_W'(OFF_IPOL):  reg_ipol  <= bus_wdata;
        ADDR_W'(OFF_FILT):  reg_filt  <= bus_wdata;
        ADDR_W'(OFF_SMODE): reg_smode <= bus_wdata;
        default: ;
      endcase
    end
  end

  assign pin_level = (reg_dir & reg_dout) | (~reg_dir & pin_sync);

  always_comb begin
    case (bus_addr)
      ADDR_W'(OFF_DOUT):  rd_mux = reg_dout;
      ADDR_W'(OFF_DIR):   rd_mux = reg_dir;
      ADDR_W'(OFF_IEN):   rd_mux = reg_ien;
      ADDR_W'(OFF_IMSK):  rd_mux = reg_imsk;
      ADDR_W'(OFF_ITYP):  rd_mux = reg_ityp;
      ADDR_W'(OFF_IPOL):  rd_mux = reg_ipol;
      ADDR_W'(OFF_ISTAT): rd_mux = irq_status;
      ADDR_W'(OFF_IRAW):  rd_mux = irq_raw;
      ADDR_W'(OFF_FILT):  rd_mux = reg_filt;
      ADDR_W'(OFF_PINS):  rd_mux = pin_level;
      ADDR_W'(OFF_SMODE): rd_mux = reg_smode;
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq       <= 1'b0;
    end else begin
      if (rd_go) bus_rdata <= rd_mux;
      irq <= |irq_status;
    end
  end

  assign pad_out = reg_dout;
  assign pad_oe  = reg_dir;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int W      = 32,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [W-1:0]      bus_rdata,
  input logic [W-1:0]      pad_out,
  input logic [W-1:0]      pad_oe,
  input logic              irq,
  input logic [W-1:0]      irq_status,
  input logic [W-1:0]      reg_imsk
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (irq == 1'b0 && pad_oe == '0 && bus_rdata == '0));

  a_r2_oe_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_write && bus_addr == ADDR_W'(OFF_DIR)) |=> $stable(pad_oe));

  a_r2_out_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && bus_write && bus_addr == ADDR_W'(OFF_DOUT)) |=> $stable(pad_out));

  a_r7_masked_quiet: assert property (@(posedge clk) disable iff (rst)
    (irq_status & reg_imsk) == '0);

  a_r8_irq_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|irq_status)));

  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !(bus_valid && !bus_write) |=> $stable(bus_rdata));
endmodule

bind gpio_bank gpio_bank_chk #(.W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .pad_out(pad_out),
  .pad_oe(pad_oe), .irq(irq), .irq_status(irq_status), .reg_imsk(reg_imsk)
);

// File: tb/gpio_bank_tb.sv
module gpio_bank_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_valid = 1'b0, bus_write = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = '0, pad_in = '0;
  logic [31:0] bus_rdata, pad_out, pad_oe;
  logic        irq;

  always #5 clk = ~clk;

  gpio_bank u_dut (
    .clk(clk), .rst(rst), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  // behavioural reference
  logic [31:0] m_dout, m_dir, m_ien, m_imsk, m_ityp, m_ipol, m_filt, m_smode;
  logic [31:0] m_s1, m_s2, m_prev, m_lat, m_rdata;
  logic        m_irq;
  int          n_cmp = 0, n_bad = 0;
  string       tag = "R1";
  bit          done = 1'b0;

  always @(posedge clk) begin
    logic [31:0] raw, stat, ack, nxt;
    if (rst) begin
      m_dout = 0; m_dir = 0; m_ien = 0; m_imsk = 0; m_ityp = 0; m_ipol = 0;
      m_filt = 0; m_smode = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_lat = 0;
      m_rdata = 0; m_irq = 0;
    end else begin
      for (int i = 0; i < 32; i++) begin
        if (!m_ien[i]) raw[i] = 1'b0;
        else if (m_ityp[i]) raw[i] = m_lat[i];
        else raw[i] = (m_s2[i] == m_ipol[i]);
      end
      stat  = raw & ~m_imsk;
      m_irq = (stat != 0);
      if (bus_valid && !bus_write) begin
        case (bus_addr)
          8'h00: m_rdata = m_dout;   8'h04: m_rdata = m_dir;
          8'h30: m_rdata = m_ien;    8'h34: m_rdata = m_imsk;
          8'h38: m_rdata = m_ityp;   8'h3C: m_rdata = m_ipol;
          8'h40: m_rdata = stat;     8'h44: m_rdata = raw;
          8'h48: m_rdata = m_filt;   8'h60: m_rdata = m_smode;
          8'h50: m_rdata = (m_dir & m_dout) | (~m_dir & m_s2);
          default: m_rdata = 0;
        endcase
      end
      ack = (bus_valid && bus_write && bus_addr == 8'h4C) ? bus_wdata : 32'h0;
      for (int i = 0; i < 32; i++) begin
        bit edge_seen;
        edge_seen = m_ipol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]);
        nxt[i] = m_ien[i] && m_ityp[i] && (edge_seen || (m_lat[i] && !ack[i]));
      end
      m_lat = nxt; m_prev = m_s2; m_s2 = m_s1; m_s1 = pad_in;
      if (bus_valid && bus_write) begin
        case (bus_addr)
          8'h00: m_dout = bus_wdata;  8'h04: m_dir = bus_wdata;
          8'h30: m_ien = bus_wdata;   8'h34: m_imsk = bus_wdata;
          8'h38: m_ityp = bus_wdata;  8'h3C: m_ipol = bus_wdata;
          8'h48: m_filt = bus_wdata;  8'h60: m_smode = bus_wdata;
          default: ;
        endcase
      end
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!done) begin
      check("R2 pad_out", pad_out, m_dout);
      check("R2 pad_oe", pad_oe, m_dir);
      check("R8 irq", {31'b0, irq}, {31'b0, m_irq});
      check({tag, " rdata"}, bus_rdata, m_rdata);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic expect_rd(logic [7:0] a, logic [31:0] exp, string req);
    @(negedge clk);
    bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_valid = 1'b0;
    check(req, bus_rdata, exp);
  endtask

  task automatic report();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    report();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1 reset values
    check("R1 irq", {31'b0, irq}, 32'h0);
    expect_rd(8'h04, 32'h0, "R1 dir");
    expect_rd(8'h30, 32'h0, "R1 enable");
    // R2 outputs and direction
    tag = "R2";
    wr(8'h00, 32'hA5A5_0F0F);
    wr(8'h04, 32'hFFFF_0000);
    check("R2 pad_oe", pad_oe, 32'hFFFF_0000);
    expect_rd(8'h00, 32'hA5A5_0F0F, "R2 readback");
    // R3 pin level
    tag = "R3";
    pad_in = 32'h1234_5678;
    idle(3);
    expect_rd(8'h50, 32'hA5A5_5678, "R3 pin level");
    wr(8'h04, 32'h0);
    expect_rd(8'h50, 32'h1234_5678, "R3 inputs");
    // R4 level sensing
    tag = "R4";
    pad_in = 32'h0;
    wr(8'h38, 32'h0); wr(8'h3C, 32'h1); wr(8'h30, 32'h3);
    idle(3);
    expect_rd(8'h44, 32'h2, "R4 active low");
    check("R8 irq set", {31'b0, irq}, 32'h1);
    pad_in = 32'h3; idle(4);
    expect_rd(8'h44, 32'h1, "R4 active high");
    pad_in = 32'h2; idle(4);
    expect_rd(8'h44, 32'h0, "R4 release");
    check("R4 irq clear", {31'b0, irq}, 32'h0);
    // R7 masking
    tag = "R7";
    pad_in = 32'h3;
    wr(8'h34, 32'h1); idle(4);
    expect_rd(8'h44, 32'h1, "R7 raw ignores mask");
    expect_rd(8'h40, 32'h0, "R7 status masked");
    check("R8 irq masked", {31'b0, irq}, 32'h0);
    wr(8'h30, 32'h0); wr(8'h34, 32'h0);
    // R5 edge sensing: pin4 rising, pin5 falling
    tag = "R5";
    wr(8'h38, 32'h30); wr(8'h3C, 32'h10);
    pad_in = 32'h20; idle(4);
    wr(8'h30, 32'h30); wr(8'h4C, 32'h30); idle(2);
    expect_rd(8'h44, 32'h0, "R5 quiet");
    pad_in = 32'h10; idle(4);
    expect_rd(8'h44, 32'h30, "R5 both edges");
    pad_in = 32'h00; idle(4);
    expect_rd(8'h44, 32'h30, "R5 held");
    // R6 acknowledge
    tag = "R6";
    wr(8'h4C, 32'h10);
    expect_rd(8'h44, 32'h20, "R6 ack one");
    wr(8'h4C, 32'h0);
    expect_rd(8'h44, 32'h20, "R6 zero ack");
    wr(8'h4C, 32'h20); idle(2);
    expect_rd(8'h44, 32'h0, "R6 ack all");
    check("R8 irq after ack", {31'b0, irq}, 32'h0);
    pad_in = 32'h20; idle(4);
    expect_rd(8'h44, 32'h0, "R6 wrong edge");
    @(negedge clk); pad_in = 32'h0;
    @(negedge clk);
    wr(8'h4C, 32'h20);
    expect_rd(8'h44, 32'h20, "R6 edge beats ack");
    // R9 inert registers
    tag = "R9";
    wr(8'h48, 32'hFFFF_FFFF); wr(8'h60, 32'h0000_005A);
    expect_rd(8'h48, 32'hFFFF_FFFF, "R9 filter");
    expect_rd(8'h60, 32'h0000_005A, "R9 sync mode");
    wr(8'h44, 32'h0); wr(8'h40, 32'h0);
    expect_rd(8'h44, 32'h20, "R9 raw read-only");
    wr(8'h4C, 32'h20);
    pad_in = 32'h20; idle(2); pad_in = 32'h0; idle(5);
    expect_rd(8'h44, 32'h20, "R9 detect unaffected");
    // R10 read timing
    tag = "R10";
    expect_rd(8'h20, 32'h0, "R10 unmapped");
    expect_rd(8'h4C, 32'h0, "R10 ack reads zero");
    idle(3);
    check("R10 hold", bus_rdata, 32'h0);
    report();
  end
endmodule